// File: doc/BRIEF.md
# Configuration Base Address Register Bank

This block keeps the six base address registers of one device's configuration header. Each slot has a fixed power-of-two window size and is either an I/O or a memory window. Both are set by parameters. A slot whose size is zero is not implemented. The block sits beside a plain configuration register file. It takes the full-dword writes that land on an implemented slot. Every other write is handed back to the plain register file through a pass-through strobe.

When a full-dword write reaches an implemented slot, the block stores the written value with the bits below the window size cleared and the type bit set. This lets software find the size by writing all-ones and reading the value back. A value other than all-ones or zero is a real base. For a real base the block first announces that the old window is released, if the slot had one. It then announces the new window with slot, base, size and type, and tells the command register which enable bit to set.

Top module: `bar_bank`

## Requirements
- R1: After reset, each implemented slot reads back only its type bit: bit 0 is 1 for an I/O slot and 0 for a memory slot. All other bits are 0, and no unmap, map or command pulse is raised.
- R2: Slot n (n = 0..5) sits at configuration byte offset 0x10 + 4n, addressed by `cfg_addr`. `bar_hit` is 1 only when `cfg_addr` names an implemented slot (non-zero size). `bar_rdata` is that slot's stored value, and 0 otherwise.
- R3: A write with `cfg_len` = 2 (4 bytes) to a dword-aligned offset of an implemented slot stores (data AND NOT(size-1)) OR type bit. The new value is readable after the next clock edge.
- R4: `cfg_len` encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = unused. A write with `cfg_len` other than 2, a write to an unaligned offset, a write to a zero-size slot, or a write outside 0x10..0x27 raises `pass_wr` in the same cycle. Such a write leaves every slot value unchanged and raises no pulse.
- R5: A claimed write of 0xFFFFFFFF or 0x00000000 updates the stored value as in R3 but raises neither unmap nor map pulse.
- R6: Any other claimed write raises `map_vld` for one cycle, two clock edges after the write. It carries the slot, the new base, the slot size and the I/O flag. The base is the written value with bits [1:0] cleared for I/O and bits [3:0] cleared for memory.
- R7: If the slot already held a base, `unmap_vld` rises for one cycle one edge after the write, carrying the old base, one cycle before the map pulse. A slot never given a base skips the unmap.
- R8: Together with a map pulse, `cmd_io_set` (command bit 0) rises for an I/O slot, or `cmd_mem_set` (command bit 1) for a memory slot.
- R9: Claimed writes on consecutive cycles each produce their own unmap/map pulses, in write order. A rewrite of the same slot unmaps the base set one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset (write and read) |
| cfg_len | input | 2 | Write length code |
| cfg_wdata | input | 32 | Write data |
| pass_wr | output | 1 | Write not claimed, goes to the plain register file |
| bar_hit | output | 1 | `cfg_addr` names an implemented slot |
| bar_rdata | output | 32 | Stored value of the addressed slot |
| unmap_vld | output | 1 | Old window released |
| unmap_slot | output | 3 | Slot being released |
| unmap_base | output | 32 | Old base |
| map_vld | output | 1 | New window programmed |
| map_slot | output | 3 | Slot being programmed |
| map_base | output | 32 | New base |
| map_size | output | 32 | Window size of the slot |
| map_io | output | 1 | Slot is an I/O window |
| cmd_io_set | output | 1 | Set I/O enable in the command register |
| cmd_mem_set | output | 1 | Set memory enable in the command register |

## Verification
The bench uses the default parameters. These give an I/O slot of 32 bytes, a 4 KiB memory slot, an unimplemented zero-size slot, a minimum 16-byte memory slot, a minimum 4-byte I/O slot and a 1 MiB memory slot. With them, each size mask, both type encodings, both base alignments and the zero-size pass-through can all be reached. Sizing writes, repeated programming of one slot and back-to-back writes to different slots exercise the skip of the first release and the ordering of the unmap and map pipelines.

// File: rtl/bar_bank.sv
module bar_bank #(
  parameter logic [6*32-1:0] SLOT_SIZE = {32'h0010_0000, 32'h0000_0004, 32'h0000_0010,
                                          32'h0000_0000, 32'h0000_1000, 32'h0000_0020},
  parameter logic [5:0]      SLOT_IO   = 6'b010001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_addr,
  input  logic [1:0]  cfg_len,
  input  logic [31:0] cfg_wdata,
  output logic        pass_wr,
  output logic        bar_hit,
  output logic [31:0] bar_rdata,
  output logic        unmap_vld,
  output logic [2:0]  unmap_slot,
  output logic [31:0] unmap_base,
  output logic        map_vld,
  output logic [2:0]  map_slot,
  output logic [31:0] map_base,
  output logic [31:0] map_size,
  output logic        map_io,
  output logic        cmd_io_set,
  output logic        cmd_mem_set
);
  localparam int NSLOT = 6;
  localparam logic [5:0] FIRST_DW = 6'd4;
  localparam logic [5:0] LAST_DW  = FIRST_DW + 6'(NSLOT - 1);

  function automatic logic [31:0] size_of(input logic [2:0] s);
    size_of = '0;
    for (int i = 0; i < NSLOT; i++)
      if (s == 3'(i)) size_of = SLOT_SIZE[i*32 +: 32];
  endfunction

  function automatic logic io_of(input logic [2:0] s);
    io_of = 1'b0;
    for (int i = 0; i < NSLOT; i++)
      if (s == 3'(i)) io_of = SLOT_IO[i];
  endfunction

  logic [31:0] val_q  [NSLOT];
  logic [31:0] base_q [NSLOT];

  logic [5:0]  dw;
  logic [2:0]  slot;
  logic        in_rng, impl, claim, remap, io;
  logic [31:0] sz, new_base, old_base;

  assign dw       = cfg_addr[7:2];
  assign in_rng   = (dw >= FIRST_DW) && (dw <= LAST_DW);
  assign slot     = 3'(dw - FIRST_DW);
  assign sz       = size_of(slot);
  assign io       = io_of(slot);
  assign impl     = in_rng && (sz != '0);
  assign claim    = cfg_wr && impl && (cfg_len == 2'd2) && (cfg_addr[1:0] == 2'b00);
  assign remap    = claim && (cfg_wdata != '1) && (cfg_wdata != '0);
  assign new_base = io ? (cfg_wdata & ~32'h3) : (cfg_wdata & ~32'hF);
  assign old_base = impl ? base_q[slot] : '1;

  assign pass_wr   = cfg_wr && !claim;
  assign bar_hit   = impl;
  assign bar_rdata = impl ? val_q[slot] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) begin
        val_q[i]  <= {31'b0, SLOT_IO[i]};
        base_q[i] <= '1;
      end
    end else if (claim) begin
      val_q[slot] <= (cfg_wdata & ~(sz - 32'd1)) | {31'b0, io};
      if (remap) base_q[slot] <= new_base;
    end
  end

  logic        pend_vld;
  logic [2:0]  pend_slot;
  logic [31:0] pend_base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unmap_vld  <= 1'b0;
      unmap_slot <= '0;
      unmap_base <= '0;
      pend_vld   <= 1'b0;
      pend_slot  <= '0;
      pend_base  <= '0;
      map_vld    <= 1'b0;
      map_slot   <= '0;
      map_base   <= '0;
    end else begin
      unmap_vld  <= remap && (old_base != '1);
      unmap_slot <= slot;
      unmap_base <= old_base;
      pend_vld   <= remap;
      pend_slot  <= slot;
      pend_base  <= new_base;
      map_vld    <= pend_vld;
      map_slot   <= pend_slot;
      map_base   <= pend_base;
    end
  end

  assign map_size    = size_of(map_slot);
  assign map_io      = io_of(map_slot);
  assign cmd_io_set  = map_vld && map_io;
  assign cmd_mem_set = map_vld && !map_io;

  AST_MAP_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    map_vld |-> $past(cfg_wr, 2) && ($past(cfg_len, 2) == 2'd2)); // R6
  AST_IO_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (map_vld && map_io) |-> (map_base[1:0] == 2'b00)); // R6
  AST_MEM_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (map_vld && !map_io) |-> (map_base[3:0] == 4'h0)); // R6
  AST_UNMAP_THEN_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    unmap_vld |=> map_vld && (map_slot == $past(unmap_slot))); // R7
  AST_PASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    pass_wr |=> !unmap_vld); // R4
  AST_HIT_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    bar_hit |-> (bar_rdata[0] == io_of(slot))); // R3
endmodule

// File: tb/sim_bar_bank.sv
module sim_bar_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [1:0]  cfg_len = '0;
  logic [31:0] cfg_wdata = '0;
  logic        pass_wr, bar_hit, unmap_vld, map_vld, map_io, cmd_io_set, cmd_mem_set;
  logic [31:0] bar_rdata, unmap_base, map_base, map_size;
  logic [2:0]  unmap_slot, map_slot;

  always #(CLK_PERIOD/2) clk = ~clk;

  bar_bank u0 (.*);

  int checks = 0;
  int fails  = 0;
  string map_tag = "R6";

  // reference: sizes and kinds as stated for the default build
  logic [31:0] r_size [6] = '{32'h20, 32'h1000, 32'h0, 32'h10, 32'h4, 32'h10_0000};
  bit          r_io   [6] = '{1, 0, 0, 0, 1, 0};
  logic [31:0] r_val  [6];
  logic [31:0] r_base [6];
  bit          e_un_v, e_pd_v, e_mp_v;
  int          e_un_s, e_pd_s, e_mp_s;
  logic [31:0] e_un_b, e_pd_b, e_mp_b;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 6; i++) begin
      r_val[i]  = {31'b0, r_io[i]};
      r_base[i] = '1;
    end
    e_un_v = 0; e_pd_v = 0; e_mp_v = 0;
    e_un_s = 0; e_pd_s = 0; e_mp_s = 0;
    e_un_b = 0; e_pd_b = 0; e_mp_b = 0;
  endtask

  function automatic int slot_of(input logic [7:0] a);
    int d = int'(a) / 4;
    return (d >= 4 && d <= 9) ? d - 4 : -1;
  endfunction

  task automatic step(input bit wr, input logic [7:0] a, input logic [1:0] len, input logic [31:0] d);
    int  s;
    bit  claimed, remap;
    logic [31:0] exp_rd;
    cfg_wr = wr; cfg_addr = a; cfg_len = len; cfg_wdata = d;
    #1;
    s = slot_of(a);
    claimed = wr && s >= 0 && r_size[s] != 0 && len == 2'd2 && a[1:0] == 2'b00;
    remap   = claimed && d != 32'hFFFF_FFFF && d != 32'h0;
    exp_rd  = (s >= 0 && r_size[s] != 0) ? r_val[s] : 32'h0;
    chk(pass_wr == (wr && !claimed), "R4", {31'b0, pass_wr}, {31'b0, wr && !claimed});
    chk(bar_hit == (s >= 0 && r_size[s] != 0), "R2", {31'b0, bar_hit}, {31'b0, s >= 0 && r_size[s] != 0});
    chk(bar_rdata == exp_rd, "R3", bar_rdata, exp_rd);
    @(posedge clk);
    e_mp_v = e_pd_v; e_mp_s = e_pd_s; e_mp_b = e_pd_b;
    e_pd_v = remap;
    if (remap) begin
      e_pd_s = s;
      e_pd_b = r_io[s] ? (d & ~32'h3) : (d & ~32'hF);
    end
    e_un_v = remap && r_base[s] != 32'hFFFF_FFFF;
    if (e_un_v) begin e_un_s = s; e_un_b = r_base[s]; end
    if (claimed) r_val[s] = (d & ~(r_size[s] - 1)) | {31'b0, r_io[s]};
    if (remap) r_base[s] = e_pd_b;
    @(negedge clk);
    chk(unmap_vld == e_un_v, "R7", {31'b0, unmap_vld}, {31'b0, e_un_v});
    if (e_un_v) begin
      chk(unmap_slot == 3'(e_un_s), "R7", {29'b0, unmap_slot}, 32'(e_un_s));
      chk(unmap_base == e_un_b, "R7", unmap_base, e_un_b);
    end
    chk(map_vld == e_mp_v, map_tag, {31'b0, map_vld}, {31'b0, e_mp_v});
    if (e_mp_v) begin
      chk(map_slot == 3'(e_mp_s), map_tag, {29'b0, map_slot}, 32'(e_mp_s));
      chk(map_base == e_mp_b, map_tag, map_base, e_mp_b);
      chk(map_size == r_size[e_mp_s], "R6", map_size, r_size[e_mp_s]);
      chk(map_io == r_io[e_mp_s], "R6", {31'b0, map_io}, {31'b0, r_io[e_mp_s]});
    end
    chk(cmd_io_set == (e_mp_v && r_io[e_mp_s]), "R8", {31'b0, cmd_io_set}, {31'b0, e_mp_v && r_io[e_mp_s]});
    chk(cmd_mem_set == (e_mp_v && !r_io[e_mp_s]), "R8", {31'b0, cmd_mem_set}, {31'b0, e_mp_v && !r_io[e_mp_s]});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 2'd0, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset contents and quiet pulses
    for (int a = 8'h0C; a <= 8'h28; a += 4) begin
      step(0, 8'(a), 2'd0, 32'h0);
      if (slot_of(8'(a)) >= 0 && r_size[slot_of(8'(a))] != 0)
        chk(bar_rdata == {31'b0, r_io[slot_of(8'(a))]}, "R1", bar_rdata, {31'b0, r_io[slot_of(8'(a))]});
      chk(!unmap_vld && !map_vld, "R1", {30'b0, unmap_vld, map_vld}, 32'h0);
    end
    // R5: sizing with all-ones, then zero, no pulses
    for (int s = 0; s < 6; s++) step(1, 8'(8'h10 + 4*s), 2'd2, 32'hFFFF_FFFF);
    idle(2);
    chk(!map_vld, "R5", {31'b0, map_vld}, 32'h0);
    step(0, 8'h14, 2'd0, 32'h0);
    chk(bar_rdata == 32'hFFFF_F000, "R5", bar_rdata, 32'hFFFF_F000);
    // R6: first programming of slots, no release
    step(1, 8'h10, 2'd2, 32'h0000_C003);
    step(1, 8'h14, 2'd2, 32'hF000_0007);
    step(1, 8'h1C, 2'd2, 32'h1234_567F);
    step(1, 8'h20, 2'd2, 32'h0000_5677);
    step(1, 8'h24, 2'd2, 32'hFEDC_BA98);
    idle(3);
    step(0, 8'h10, 2'd0, 32'h0);
    chk(bar_rdata == 32'h0000_C001, "R3", bar_rdata, 32'h0000_C001);
    // R7: reprogram releases the old base
    step(1, 8'h10, 2'd2, 32'h0000_D000);
    idle(3);
    // R5: zero write keeps mapping quiet
    step(1, 8'h14, 2'd2, 32'h0);
    idle(3);
    chk(!map_vld && !unmap_vld, "R5", {30'b0, unmap_vld, map_vld}, 32'h0);
    // R4: fall-through cases
    step(1, 8'h14, 2'd1, 32'hAAAA_5555);
    step(1, 8'h14, 2'd0, 32'h1111_1111);
    step(1, 8'h15, 2'd2, 32'h2222_2220);
    step(1, 8'h18, 2'd2, 32'h3333_3330);
    step(1, 8'h04, 2'd2, 32'h4444_4440);
    step(1, 8'h28, 2'd2, 32'h5555_5550);
    step(1, 8'h14, 2'd3, 32'h6666_6660);
    idle(3);
    step(0, 8'h14, 2'd0, 32'h0);
    chk(bar_rdata == 32'h0, "R4", bar_rdata, 32'h0);
    // R9: back-to-back writes
    map_tag = "R9";
    step(1, 8'h1C, 2'd2, 32'h0000_8000);
    step(1, 8'h20, 2'd2, 32'h0000_9004);
    step(1, 8'h1C, 2'd2, 32'h0000_A010);
    step(1, 8'h10, 2'd2, 32'h0000_E020);
    idle(4);
    map_tag = "R6";
    // reset again restores R1 state
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    step(0, 8'h10, 2'd0, 32'h0);
    chk(bar_rdata == 32'h1, "R1", bar_rdata, 32'h1);
    step(1, 8'h10, 2'd2, 32'h0000_C000);
    idle(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule